// File: doc/BRIEF.md
# Interlaced Composite Sync Generator

This block derives all the sync timing for an interlaced analog raster from one fixed-frequency clock. A tick counter divides the clock into half-line units. A line counter steps once per two half-lines and returns to zero after the last line of the frame. Every duration is a parameter in clock ticks. The defaults use one tick per microsecond: a 64-tick line, 625 lines, and 312.5 lines per field.

Outside the vertical interval the block sends one short sync pulse at the start of each line. At each field boundary it can run the vertical sequence instead. That sequence is a group of narrow equalizing pulses, then a group of broad pulses, then a second group of equalizing pulses, all on a half-line grid. The broad pulses are serrated by a short high gap at the end of each half line, so the receiver's line oscillator stays locked during vertical retrace. Field 0 starts at the beginning of line 0 and field 1 starts at the middle of line 312, which gives the half-line offset between the two fields.

A frame controller arms the next vertical sequence with a one-cycle strobe. The block answers with a one-cycle done strobe when the second equalizing group has ended. The block has five outputs, all registered: composite sync (active low), an active-video enable, the line number, the field flag, and the done strobe.

Top module: `csync_gen`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, the outputs show the first tick of the frame. Line and field are 0, active video is low and done is low. Composite sync is low, because reset counts as an armed start and the first equalizing pulse begins at once.
- R2: A line lasts 2*HALF_TICKS cycles. line_o increments at every line start and wraps from LINES-1 to 0.
- R3: Outside the vertical sequence, csync_o is low for the first HSYNC_TICKS cycles of each line and high for the rest of the line. There is no pulse at mid-line.
- R4: field_o is 0 from the start of line 0 up to the midpoint of line LINES/2 (rounded down), and 1 from that midpoint to the end of the frame. It therefore toggles once per field.
- R5: A vertical sequence begins only at a field boundary (the start of line 0, or the midpoint of line LINES/2). It begins only if a start strobe has been sampled since the previous sequence began, and a strobe sampled on the last tick before the boundary counts.
- R6: A sequence opens with PRE_EQ half-lines. Each one begins with csync_o low for EQ_TICKS cycles.
- R7: The next BROAD_N half-lines each hold csync_o low for HALF_TICKS-HSYNC_TICKS cycles from the start of the half-line, then high for the remaining HSYNC_TICKS cycles.
- R8: The last POST_EQ half-lines carry equalizing pulses like those of R6. After them, normal line sync resumes at the next line start. No pulse is sent in a half-line that lies between the end of the sequence and the next line start.
- R9: vsync_done_o is high for exactly one cycle: the first cycle after the last post-equalizing half-line.
- R10: At a field boundary with no armed start, the block gives plain line sync and raises no done strobe.
- R11: active_o is high only on lines outside the blanking bands and only within the visible window. The blanking bands are lines 0 to BLANK_LINES-1 and lines LINES/2 to LINES/2+BLANK_LINES-1. The visible window runs from HSYNC_TICKS+BACK_TICKS ticks into the line up to FRONT_TICKS ticks before its end.
- R12: A start strobe that arrives while a sequence is running arms the sequence at the following field boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fixed-frequency timebase clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsync_start_i | input | 1 | One-cycle strobe that arms the next vertical sequence |
| csync_o | output | 1 | Composite sync, active low |
| active_o | output | 1 | Active-video enable |
| line_o | output | $clog2(LINES) | Current line number |
| field_o | output | 1 | Field flag (0 or 1) |
| vsync_done_o | output | 1 | One-cycle strobe after the post-equalizing group |

## Verification
Two of the block's functions can fall in the same cycle. One is the arming of a sequence by the start strobe. The other is the field-boundary decision, which is taken on the last tick of a half-line. The bench lands one strobe exactly on the tick before the frame boundary, and it expects a full sequence to begin on the next tick. It also sends a strobe in the middle of a running sequence and expects it to arm the next field rather than be lost. Every cycle of the run is judged against a behavioural model of position and sequence state.

// File: rtl/csync_pkg.sv
package csync_pkg;
  typedef enum logic [1:0] {
    PK_NONE,
    PK_HSYNC,
    PK_EQ,
    PK_BROAD
  } pulse_e;
endpackage

// File: rtl/csync_timebase.sv
module csync_timebase #(
  parameter int HALF_TICKS = 32,
  parameter int LINES      = 625,
  localparam int TW = $clog2(HALF_TICKS),
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          hl_end_o,
  output logic [TW-1:0] tick_n_o,
  output logic          half_n_o,
  output logic [LW-1:0] line_n_o,
  output logic          fstart_n_o,
  output logic          fstart_o
);
  localparam logic [TW-1:0] TICK_LAST  = TW'(HALF_TICKS - 1);
  localparam logic [LW-1:0] LINE_LAST  = LW'(LINES - 1);
  localparam logic [LW-1:0] FIELD_LINE = LW'(LINES / 2);

  logic [TW-1:0] tick_q;
  logic          half_q;
  logic [LW-1:0] line_q;

  function automatic logic at_fs(input logic [TW-1:0] t, input logic h, input logic [LW-1:0] l);
    return (t == '0) && ((l == '0 && !h) || (l == FIELD_LINE && h));
  endfunction

  always_comb begin
    hl_end_o = (tick_q == TICK_LAST);
    tick_n_o = hl_end_o ? '0 : tick_q + 1'b1;
    half_n_o = hl_end_o ? ~half_q : half_q;
    line_n_o = line_q;
    if (hl_end_o && half_q)
      line_n_o = (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
    fstart_n_o = at_fs(tick_n_o, half_n_o, line_n_o);
    fstart_o   = at_fs(tick_q, half_q, line_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      half_q <= 1'b0;
      line_q <= '0;
    end else begin
      tick_q <= tick_n_o;
      half_q <= half_n_o;
      line_q <= line_n_o;
    end
  end

  // R2
  line_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_q == LINE_LAST && half_q && hl_end_o) |=> (line_q == '0));

  // R2
  line_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_q <= LINE_LAST);
endmodule

// File: rtl/csync_vseq.sv
module csync_vseq
  import csync_pkg::*;
#(
  parameter int PRE_EQ  = 5,
  parameter int BROAD_N = 5,
  parameter int POST_EQ = 5,
  localparam int SEQ_LEN = PRE_EQ + BROAD_N + POST_EQ,
  localparam int IW      = $clog2(SEQ_LEN)
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   hl_end_i,
  input  logic   fstart_n_i,
  input  logic   fstart_i,
  input  logic   half_n_i,
  output pulse_e kind_n_o,
  output logic   done_o
);
  localparam logic [IW-1:0] IDX_LAST  = IW'(SEQ_LEN - 1);
  localparam logic [IW-1:0] PRE_END   = IW'(PRE_EQ);
  localparam logic [IW-1:0] BROAD_END = IW'(PRE_EQ + BROAD_N);

  logic          armed_q, act_q, done_q;
  logic [IW-1:0] idx_q;
  logic          armed_n, act_n, done_n, arm_eff;
  logic [IW-1:0] idx_n;

  always_comb begin
    arm_eff = armed_q | start_i;
    armed_n = arm_eff;
    act_n   = act_q;
    idx_n   = idx_q;
    done_n  = 1'b0;
    if (hl_end_i) begin
      if (act_q) begin
        if (idx_q == IDX_LAST) begin
          act_n  = 1'b0;
          done_n = 1'b1;
        end else begin
          idx_n = idx_q + 1'b1;
        end
      end else if (fstart_n_i && arm_eff) begin
        act_n   = 1'b1;
        idx_n   = '0;
        armed_n = 1'b0;
      end
    end
    if (act_n) begin
      if (idx_n < PRE_END)        kind_n_o = PK_EQ;
      else if (idx_n < BROAD_END) kind_n_o = PK_BROAD;
      else                        kind_n_o = PK_EQ;
    end else begin
      kind_n_o = half_n_i ? PK_NONE : PK_HSYNC;
    end
  end

  // reset counts as an armed start: field 0 opens with its vertical sequence
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      act_q   <= 1'b1;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      armed_q <= armed_n;
      act_q   <= act_n;
      idx_q   <= idx_n;
      done_q  <= done_n;
    end
  end

  assign done_o = done_q;

  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R9
  done_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!act_q && $past(act_q)));

  // R5
  seq_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> fstart_i);

  // R5
  seq_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> $past(armed_q || start_i));
endmodule

// File: rtl/csync_shaper.sv
module csync_shaper
  import csync_pkg::*;
#(
  parameter int HALF_TICKS  = 32,
  parameter int LINES       = 625,
  parameter int HSYNC_TICKS = 5,
  parameter int EQ_TICKS    = 2,
  parameter int BACK_TICKS  = 6,
  parameter int FRONT_TICKS = 2,
  parameter int BLANK_LINES = 25,
  localparam int TW = $clog2(HALF_TICKS),
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  pulse_e        kind_n_i,
  input  logic [TW-1:0] tick_n_i,
  input  logic          half_n_i,
  input  logic [LW-1:0] line_n_i,
  output logic          csync_o,
  output logic          active_o,
  output logic [LW-1:0] line_o,
  output logic          field_o
);
  localparam logic [TW-1:0] W_HS    = TW'(HSYNC_TICKS);
  localparam logic [TW-1:0] W_EQ    = TW'(EQ_TICKS);
  localparam logic [TW-1:0] W_BROAD = TW'(HALF_TICKS - HSYNC_TICKS);
  localparam logic [TW-1:0] VIS_LO  = TW'(HSYNC_TICKS + BACK_TICKS);
  localparam logic [TW-1:0] VIS_HI  = TW'(HALF_TICKS - FRONT_TICKS);
  localparam logic [LW-1:0] FLINE   = LW'(LINES / 2);
  localparam logic [LW-1:0] BL0     = LW'(BLANK_LINES);
  localparam logic [LW-1:0] BL1     = LW'(LINES / 2 + BLANK_LINES);

  logic [TW-1:0] low_w;
  logic          csync_n, active_n, field_n, vbi_n, vis_n;

  always_comb begin
    unique case (kind_n_i)
      PK_HSYNC: low_w = W_HS;
      PK_EQ:    low_w = W_EQ;
      PK_BROAD: low_w = W_BROAD;
      default:  low_w = '0;
    endcase
    csync_n  = !(tick_n_i < low_w);
    field_n  = (line_n_i > FLINE) || (line_n_i == FLINE && half_n_i);
    vbi_n    = (line_n_i < BL0) || (line_n_i >= FLINE && line_n_i < BL1);
    vis_n    = half_n_i ? (tick_n_i < VIS_HI) : (tick_n_i >= VIS_LO);
    active_n = !vbi_n && vis_n;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csync_o  <= 1'b0;
      active_o <= 1'b0;
      line_o   <= '0;
      field_o  <= 1'b0;
    end else begin
      csync_o  <= csync_n;
      active_o <= active_n;
      line_o   <= line_n_i;
      field_o  <= field_n;
    end
  end

  // R11
  sync_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csync_o |-> !active_o);
endmodule

// File: rtl/csync_gen.sv
module csync_gen
  import csync_pkg::*;
#(
  parameter int HALF_TICKS  = 32,
  parameter int LINES       = 625,
  parameter int HSYNC_TICKS = 5,
  parameter int EQ_TICKS    = 2,
  parameter int BACK_TICKS  = 6,
  parameter int FRONT_TICKS = 2,
  parameter int BLANK_LINES = 25,
  parameter int PRE_EQ      = 5,
  parameter int BROAD_N     = 5,
  parameter int POST_EQ     = 5,
  localparam int TW = $clog2(HALF_TICKS),
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vsync_start_i,
  output logic          csync_o,
  output logic          active_o,
  output logic [LW-1:0] line_o,
  output logic          field_o,
  output logic          vsync_done_o
);
  logic          hl_end, half_n, fstart_n, fstart_c;
  logic [TW-1:0] tick_n;
  logic [LW-1:0] line_n;
  pulse_e        kind_n;

  csync_timebase #(.HALF_TICKS(HALF_TICKS), .LINES(LINES)) u_tb (
    .clk_i, .rst_ni,
    .hl_end_o(hl_end), .tick_n_o(tick_n), .half_n_o(half_n), .line_n_o(line_n),
    .fstart_n_o(fstart_n), .fstart_o(fstart_c)
  );

  csync_vseq #(.PRE_EQ(PRE_EQ), .BROAD_N(BROAD_N), .POST_EQ(POST_EQ)) u_seq (
    .clk_i, .rst_ni,
    .start_i(vsync_start_i), .hl_end_i(hl_end), .fstart_n_i(fstart_n),
    .fstart_i(fstart_c), .half_n_i(half_n), .kind_n_o(kind_n), .done_o(vsync_done_o)
  );

  csync_shaper #(
    .HALF_TICKS(HALF_TICKS), .LINES(LINES), .HSYNC_TICKS(HSYNC_TICKS),
    .EQ_TICKS(EQ_TICKS), .BACK_TICKS(BACK_TICKS), .FRONT_TICKS(FRONT_TICKS),
    .BLANK_LINES(BLANK_LINES)
  ) u_shp (
    .clk_i, .rst_ni,
    .kind_n_i(kind_n), .tick_n_i(tick_n), .half_n_i(half_n), .line_n_i(line_n),
    .csync_o, .active_o, .line_o, .field_o
  );

  // R4
  field_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_o != $past(field_o)) |-> fstart_c);
endmodule

// File: tb/test_csync_gen.sv
module test_csync_gen;
  localparam int HALF = 32, LINES = 625, HS = 5, EQ = 2, BP = 6, FP = 2, BL = 25;
  localparam int PRE = 5, BRN = 5, POST = 5;
  localparam int LINE_T = 2 * HALF, FRAME_T = LINES * LINE_T, FL = LINES / 2;
  localparam int SEQ_T = (PRE + BRN + POST) * HALF;
  localparam int F1_POS = FL * LINE_T + HALF;
  localparam int RUN = 82000;

  logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic       csync, active, field, done;
  logic [9:0] line;

  csync_gen #(
    .HALF_TICKS(HALF), .LINES(LINES), .HSYNC_TICKS(HS), .EQ_TICKS(EQ),
    .BACK_TICKS(BP), .FRONT_TICKS(FP), .BLANK_LINES(BL),
    .PRE_EQ(PRE), .BROAD_N(BRN), .POST_EQ(POST)
  ) i_csync_gen (
    .clk_i(clk), .rst_ni(rst_n), .vsync_start_i(start),
    .csync_o(csync), .active_o(active), .line_o(line), .field_o(field),
    .vsync_done_o(done)
  );

  always #5 clk = ~clk;

  int n_run = 0, n_fail = 0, cur_n = 0;
  bit ended = 1'b0;
  int seq_s = 0;
  bit armed = 1'b0;
  int done_t[$];
  int toggles = 0;
  logic prev_field = 1'b0;
  logic cs_r8 = 1'b0, cs_r10 = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cur_n, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  function automatic bit is_fb(input int p);
    return (p == 0) || (p == F1_POS);
  endfunction

  task automatic compare(input int n);
    int p, ln, tip, hf, t, k, ts, w;
    bit in_seq, vbi, win;
    logic ecs, efl, eact, edn;
    string tag;
    p = n % FRAME_T; ln = p / LINE_T; tip = p % LINE_T; hf = tip / HALF; t = tip % HALF;
    in_seq = (n >= seq_s) && (n < seq_s + SEQ_T);
    if (in_seq) begin
      k = (n - seq_s) / HALF; ts = (n - seq_s) % HALF;
      w = (k < PRE || k >= PRE + BRN) ? EQ : HALF - HS;
      ecs = !(ts < w);
      tag = (k < PRE) ? "R6" : (k < PRE + BRN) ? "R7" : "R8";
    end else begin
      ecs = !(tip < HS);
      tag = "R3";
    end
    efl  = (p >= F1_POS);
    vbi  = (ln < BL) || (ln >= FL && ln < FL + BL);
    win  = hf ? (t < HALF - FP) : (t >= HS + BP);
    eact = !vbi && win;
    edn  = (n == seq_s + SEQ_T);
    cur_n = n;
    chk(csync === ecs, tag, int'(csync), int'(ecs));
    chk(int'(line) == ln, "R2", int'(line), ln);
    chk(field === efl, "R4", int'(field), int'(efl));
    chk(active === eact, "R11", int'(active), int'(eact));
    chk(done === edn, "R9", int'(done), int'(edn));
  endtask

  initial begin
    #((RUN + 100) * 10 * 2);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(csync === 1'b0, "R1", int'(csync), 0);
    chk(int'(line) == 0, "R1", int'(line), 0);
    chk(field === 1'b0, "R1", int'(field), 0);
    chk(active === 1'b0, "R1", int'(active), 0);
    chk(done === 1'b0, "R1", int'(done), 0);
    rst_n = 1'b1;
    for (int n = 0; n < RUN; n++) begin
      #1;
      compare(n);
      if (done === 1'b1) done_t.push_back(n);
      if (field !== prev_field) toggles++;
      prev_field = field;
      if (n == 481) cs_r8 = csync;
      if (n == 80000 + HALF + 1) cs_r10 = csync;
      if (n_fail > 40) break;
      // strobe at 39999 lands on the boundary decision (R5); 40100 during a sequence (R12)
      start = (n == 5000 || n == 39999 || n == 40100);
      if (start) armed = 1'b1;
      if (is_fb((n + 1) % FRAME_T) && armed) begin
        seq_s = n + 1;
        armed = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    cur_n = RUN;
    // R9: done strobes of the armed sequences
    chk(done_t.size() == 4, "R9", done_t.size(), 4);
    if (done_t.size() >= 4) begin
      chk(done_t[0] == SEQ_T, "R9", done_t[0], SEQ_T);
      chk(done_t[1] == F1_POS + SEQ_T, "R5", done_t[1], F1_POS + SEQ_T);
      chk(done_t[2] == FRAME_T + SEQ_T, "R5", done_t[2], FRAME_T + SEQ_T);
      chk(done_t[3] == FRAME_T + F1_POS + SEQ_T, "R12", done_t[3], FRAME_T + F1_POS + SEQ_T);
    end
    // R10: unarmed boundary gives no sequence
    chk(cs_r10 === 1'b1, "R10", int'(cs_r10), 1);
    // R8: half-line after field 0 sequence has no pulse
    chk(cs_r8 === 1'b1, "R8", int'(cs_r8), 1);
    // R4: one toggle per field boundary crossed
    chk(toggles == 4, "R4", toggles, 4);
    finish_run();
  end
endmodule